// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Soma

This block is the cell body of one output neuron in a spiking network. On each time step it adds all of its weighted post-synaptic inputs into a signed membrane potential. It emits an axonal spike when the updated potential rises above a programmable threshold. After a spike, the potential drops to a hyperpolarised level that lies below the resting level.

In a step where every input is zero, the potential leaks linearly toward rest by a configurable amount. The leak stops once the potential reaches rest. A separate frame-start input returns the potential to rest, so each encoding time frame begins from a known state. The step enable is driven on the same pace as the synapse array that feeds the block.

The inputs are summed in one parallel adder tree, so a whole step completes in a single clock cycle.

Top module: `lif_soma`

## Requirements
- R1: A synchronous active-high reset sets `potential` to 0 and `spike` to 0.
- R2: In a cycle with `step_en` high, `frame_rst` low and at least one nonzero input lane, the next `potential` equals the current one plus the unsigned sum of all lanes. Lane i occupies `syn_in[8i+7:8i]`.
- R3: The integrated potential saturates at +32767 and never wraps.
- R4: A step fires when its newly computed potential is strictly greater than the signed `thresh`. `spike` is then high for exactly the following cycle. A value equal to the threshold does not fire.
- R5: When a step fires, the next `potential` equals `hyper_lvl`.
- R6: In a step where every lane is zero, a potential above `rest_lvl` drops by `leak_amt` but not below `rest_lvl`. A potential at or below `rest_lvl` is left unchanged.
- R7: In a cycle with `step_en` and `frame_rst` both low, `potential` holds its value and `spike` is low, whatever the lanes carry.
- R8: `frame_rst` takes priority over `step_en`. The next `potential` equals `rest_lvl` and `spike` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance one time step |
| frame_rst | input | 1 | Return potential to rest at frame start |
| syn_in | input | 256 | 32 unsigned 8-bit weighted inputs; lane i at bits 8i+7:8i |
| thresh | input | 16 | Signed firing threshold |
| leak_amt | input | 15 | Linear decay per idle step |
| rest_lvl | input | 16 | Signed resting potential |
| hyper_lvl | input | 16 | Signed post-spike hyperpolarisation level |
| potential | output | 16 | Signed membrane potential |
| spike | output | 1 | Single-cycle axonal spike |

## Verification
On every cycle, the assertions check the following: the potential holds while idle, a spike only follows a step and lands the potential on the hyperpolarisation level, an active step never lowers the potential unless the neuron fires, and a silent step never drops the potential below rest. Other behaviours can only be shown by the bench's scenarios, which drive the neuron toward known values. These are the exact sum across all 32 lanes, saturation at the top of the range, and the strict boundary at a threshold equal to the potential. A behavioural model then follows a long stretch of sparse stimulus.

// File: rtl/lif_pkg.sv
package lif_pkg;

    localparam int POT_W = 16;

    typedef logic signed [POT_W-1:0] pot_t;

    localparam pot_t POT_MAX = pot_t'({1'b0, {(POT_W-1){1'b1}}});

    typedef struct packed {
        pot_t             thresh;
        logic [POT_W-2:0] leak;
        pot_t             rest;
        pot_t             hyper;
    } cfg_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_FRAME,
        ACT_INTEGRATE,
        ACT_LEAK
    } act_e;

    typedef struct packed {
        pot_t value;
        logic fire;
    } upd_t;

    // Add an unsigned increment, clipping at the positive limit.
    function automatic pot_t sat_add(pot_t a, logic [POT_W-1:0] b);
        logic signed [POT_W+1:0] s;
        s = $signed({a[POT_W-1], a[POT_W-1], a}) + $signed({2'b00, b});
        if (s > $signed({2'b00, POT_MAX}))
            return POT_MAX;
        return pot_t'(s[POT_W-1:0]);
    endfunction

    // Linear decay toward rest; inert at or below rest.
    function automatic pot_t leak_step(pot_t p, logic [POT_W-2:0] amt, pot_t rest);
        logic signed [POT_W:0] d;
        if (p <= rest)
            return p;
        d = $signed({p[POT_W-1], p}) - $signed({2'b00, amt});
        if (d < $signed({rest[POT_W-1], rest}))
            return rest;
        return pot_t'(d[POT_W-1:0]);
    endfunction

endpackage

// File: rtl/lif_adder_tree.sv
module lif_adder_tree #(
    parameter int N_IN  = 32,
    parameter int IN_W  = 8,
    parameter int SUM_W = IN_W + $clog2(N_IN + 1)
) (
    input  logic [N_IN*IN_W-1:0] vec,
    output logic [SUM_W-1:0]     total,
    output logic                 any_active
);

    logic [IN_W-1:0]  lane [N_IN];
    logic [SUM_W-1:0] node [1:2*N_IN-1];

    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_lane
            assign lane[g] = vec[g*IN_W +: IN_W];
        end
    endgenerate

    // Heap-ordered tree: leaves at N_IN..2*N_IN-1, root at 1.
    always_comb begin
        for (int i = 0; i < N_IN; i++)
            node[N_IN+i] = SUM_W'(lane[i]);
        for (int k = N_IN - 1; k >= 1; k--)
            node[k] = node[2*k] + node[2*k+1];
    end

    assign total      = node[1];
    assign any_active = |vec;

endmodule

// File: rtl/lif_update.sv
module lif_update
    import lif_pkg::*;
(
    input  pot_t             pot,
    input  logic [POT_W-1:0] sum,
    input  logic             active,
    input  logic             step,
    input  logic             frame,
    input  cfg_t             cfg,
    output upd_t             nxt
);

    act_e act;
    pot_t cand;
    logic fire;

    always_comb begin
        if (frame)
            act = ACT_FRAME;
        else if (step)
            act = active ? ACT_INTEGRATE : ACT_LEAK;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_FRAME:     cand = cfg.rest;
            ACT_INTEGRATE: cand = sat_add(pot, sum);
            ACT_LEAK:      cand = leak_step(pot, cfg.leak, cfg.rest);
            default:       cand = pot;
        endcase
        fire = ((act == ACT_INTEGRATE) || (act == ACT_LEAK)) && (cand > cfg.thresh);
        nxt.value = fire ? cfg.hyper : cand;
        nxt.fire  = fire;
    end

endmodule

// File: rtl/lif_soma.sv
module lif_soma
    import lif_pkg::*;
#(
    parameter int N_IN = 32,
    parameter int IN_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic                    frame_rst,
    input  logic [N_IN*IN_W-1:0]    syn_in,
    input  logic signed [15:0]      thresh,
    input  logic [14:0]             leak_amt,
    input  logic signed [15:0]      rest_lvl,
    input  logic signed [15:0]      hyper_lvl,
    output logic signed [15:0]      potential,
    output logic                    spike
);

    localparam int SUM_W = IN_W + $clog2(N_IN + 1);

    logic [SUM_W-1:0] tree_sum;
    logic [POT_W-1:0] sum_clip;
    logic             active;
    cfg_t             cfg;
    upd_t             nxt;
    pot_t             pot_q;
    logic             spike_q;

    lif_adder_tree #(
        .N_IN  (N_IN),
        .IN_W  (IN_W),
        .SUM_W (SUM_W)
    ) u_tree (
        .vec        (syn_in),
        .total      (tree_sum),
        .any_active (active)
    );

    generate
        if (SUM_W < POT_W) begin : g_sum_ext
            assign sum_clip = {{(POT_W-SUM_W){1'b0}}, tree_sum};
        end else begin : g_sum_clamp
            assign sum_clip = (tree_sum > SUM_W'(POT_MAX)) ? POT_W'(POT_MAX)
                                                          : tree_sum[POT_W-1:0];
        end
    endgenerate

    assign cfg = '{thresh: thresh, leak: leak_amt, rest: rest_lvl, hyper: hyper_lvl};

    lif_update u_upd (
        .pot    (pot_q),
        .sum    (sum_clip),
        .active (active),
        .step   (step_en),
        .frame  (frame_rst),
        .cfg    (cfg),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pot_q   <= '0;
            spike_q <= 1'b0;
        end else begin
            pot_q   <= nxt.value;
            spike_q <= nxt.fire;
        end
    end

    assign potential = pot_q;
    assign spike     = spike_q;

endmodule

// File: rtl/lif_soma_chk.sv
module lif_soma_chk #(
    parameter int N_IN = 32,
    parameter int IN_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 step_en,
    input logic                 frame_rst,
    input logic [N_IN*IN_W-1:0] syn_in,
    input logic signed [15:0]   rest_lvl,
    input logic signed [15:0]   hyper_lvl,
    input logic signed [15:0]   potential,
    input logic                 spike
);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en && !frame_rst |=> $stable(potential) && !spike);

    // R8
    frame_rest_chk: assert property (@(posedge clk) disable iff (rst)
        frame_rst |=> (potential == $past(rest_lvl)) && !spike);

    // R4
    spike_after_step_chk: assert property (@(posedge clk) disable iff (rst)
        spike |-> $past(step_en && !frame_rst));

    // R5
    spike_hyper_chk: assert property (@(posedge clk) disable iff (rst)
        spike |-> potential == $past(hyper_lvl));

    // R2
    active_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        step_en && !frame_rst && (syn_in != '0) |=> spike || (potential >= $past(potential)));

    // R6
    leak_floor_chk: assert property (@(posedge clk) disable iff (rst)
        step_en && !frame_rst && (syn_in == '0) && (potential >= rest_lvl) |=>
            spike || ((potential <= $past(potential)) && (potential >= $past(rest_lvl))));

endmodule

bind lif_soma lif_soma_chk #(.N_IN(N_IN), .IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .frame_rst (frame_rst),
    .syn_in    (syn_in),
    .rest_lvl  (rest_lvl),
    .hyper_lvl (hyper_lvl),
    .potential (potential),
    .spike     (spike)
);

// File: tb/lif_soma_bench.sv
module lif_soma_bench;

    localparam int N = 32;
    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                rst = 1'b1;
    logic                step_en = 1'b0;
    logic                frame_rst = 1'b0;
    logic [N*W-1:0]      syn_in = '0;
    logic signed [15:0]  thresh = 16'sd1000;
    logic [14:0]         leak_amt = 15'd10;
    logic signed [15:0]  rest_lvl = -16'sd50;
    logic signed [15:0]  hyper_lvl = -16'sd200;
    logic signed [15:0]  potential;
    logic                spike;

    int checks = 0;
    int fails  = 0;
    int m_pot  = 0;
    int m_spk  = 0;

    lif_soma u_lif_soma (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .frame_rst (frame_rst),
        .syn_in    (syn_in),
        .thresh    (thresh),
        .leak_amt  (leak_amt),
        .rest_lvl  (rest_lvl),
        .hyper_lvl (hyper_lvl),
        .potential (potential),
        .spike     (spike)
    );

    task automatic check(string req, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Behavioural model of one clock edge, from the requirements.
    task automatic model_edge();
        int sum;
        int c;
        sum = 0;
        for (int i = 0; i < N; i++) sum += int'(syn_in[i*W +: W]);
        if (rst) begin
            m_pot = 0; m_spk = 0;
        end else if (frame_rst) begin
            m_pot = int'(rest_lvl); m_spk = 0;
        end else if (step_en) begin
            if (sum != 0) begin
                c = m_pot + sum;
                if (c > 32767) c = 32767;
            end else if (m_pot > int'(rest_lvl)) begin
                c = m_pot - int'(leak_amt);
                if (c < int'(rest_lvl)) c = int'(rest_lvl);
            end else begin
                c = m_pot;
            end
            if (c > int'(thresh)) begin
                m_pot = int'(hyper_lvl); m_spk = 1;
            end else begin
                m_pot = c; m_spk = 0;
            end
        end else begin
            m_spk = 0;
        end
    endtask

    task automatic cycle(string req, bit st, bit fr);
        @(negedge clk);
        step_en   = st;
        frame_rst = fr;
        @(posedge clk);
        model_edge();
        #1;
        check(req, int'(potential), m_pot, "potential");
        check(req, int'(spike), m_spk, "spike");
    endtask

    task automatic set_all(int v);
        for (int i = 0; i < N; i++) syn_in[i*W +: W] = W'(v);
    endtask

    task automatic set_lane(int idx, int v);
        syn_in[idx*W +: W] = W'(v);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        rst = 1'b1;
        cycle("R1", 1'b1, 1'b0);
        cycle("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R8: frame start loads rest
        cycle("R8", 1'b0, 1'b1);

        // R2: single lane, then all lanes
        set_lane(5, 100);
        cycle("R2 single lane", 1'b1, 1'b0);
        set_all(20);
        cycle("R2 all lanes", 1'b1, 1'b0);

        // R7: inputs present but no step
        set_all(77);
        cycle("R7 hold", 1'b0, 1'b0);
        cycle("R7 hold", 1'b0, 1'b0);

        // R6: leak to rest and clamp
        syn_in   = '0;
        leak_amt = 15'd300;
        for (int k = 0; k < 4; k++) cycle("R6 leak", 1'b1, 1'b0);

        // R4: equal to threshold does not fire, one above does
        set_lane(0, 255); set_lane(1, 255); set_lane(2, 255); set_lane(3, 255);
        set_lane(4, 30);
        cycle("R4 equal", 1'b1, 1'b0);
        syn_in = '0;
        set_lane(0, 1);
        cycle("R4 fire", 1'b1, 1'b0);
        check("R5 hyper", int'(potential), -200, "potential");
        syn_in = '0;
        cycle("R4 single pulse", 1'b0, 1'b0);

        // R6: at hyperpolarised level, silent step leaves it alone
        cycle("R6 below rest", 1'b1, 1'b0);

        // R3: saturation
        thresh = 16'sd32767;
        set_all(255);
        for (int k = 0; k < 6; k++) cycle("R3 saturate", 1'b1, 1'b0);
        check("R3 max", int'(potential), 32767, "potential");

        // R8: frame start wins over a step
        cycle("R8 priority", 1'b1, 1'b1);

        // Sparse random run against the model
        thresh    = 16'sd1500;
        leak_amt  = 15'd25;
        rest_lvl  = -16'sd30;
        hyper_lvl = -16'sd300;
        for (int k = 0; k < 600; k++) begin
            for (int i = 0; i < N; i++)
                set_lane(i, (($urandom % 8) == 0) ? int'($urandom % 40) : 0);
            if (($urandom % 4) == 0) syn_in = '0;
            cycle("R2/R4/R5/R6 random", ($urandom % 4) != 0, ($urandom % 40) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule